// File: doc/BRIEF.md
# Paced Reconfiguration Bitstream Sink

This block takes in a configuration bitstream after a start pulse. The words arrive on a valid/ready streaming sink. For the whole operation the block holds a freeze output high, so that the region being rewritten stays isolated. Acceptance is throttled: `data_ready` is high for one cycle in every `RATIO` cycles, which models a configuration engine that needs several clocks per word. Each accepted word is passed on at once on a write strobe (`cfg_wen`/`cfg_wdata`) to the configuration writer. The number of words in the bitstream is given on `word_total` when start is seen.

Back-pressure rules: a word moves only on a cycle where `data_valid` and `data_ready` are both high. The sink has zero ready latency. `data_ready` never depends on `data_valid`. A source that sees `data_ready` low must hold its word. After the last word has been taken, `data_ready` stays low. Any further words the source offers (dummy fill) are never taken. When the last word is in, the block spends `DRAIN_CYC` cycles on processing. It then drops freeze and posts the result on `status`. Error conditions are injected on three plain inputs. A CRC error may still arrive after a clean finish, and it then replaces the success code.

Top module: `bitstream_sink`

## Requirements
- R1: A `start` high while freeze is low begins an operation: freeze is high from the next cycle. A `start` while freeze is high has no effect, including a new `word_total`.
- R2: The edge that accepts `start` clears `status` to 000, and it reads 000 while the operation runs with no error.
- R3: A word is consumed only on a cycle with `data_valid` and `data_ready` both high. In that same cycle `cfg_wen` is 1 and `cfg_wdata` equals `data`. `data_valid` may first rise any number of cycles after start.
- R4: `data_ready` is high in the first cycle after start is accepted, and then exactly one cycle in every `RATIO` cycles while words are expected, whatever `data_valid` does.
- R5: After `word_total` words have been accepted (a total of 0 counts as 1), `data_ready` and `cfg_wen` stay low for the rest of the operation, even with `data_valid` held high.
- R6: Freeze stays high for exactly `DRAIN_CYC` cycles after the cycle of the last accepted word, then falls. If no error was seen, `status` becomes 100 (success) on that same edge.
- R7: While freeze is high, `err_cfg` sets status 001, `err_crc` sets 010 and `err_incompat` sets 011 on the next cycle. If several errors arrive together, incompatible wins over configuration error, which wins over CRC error. The first error recorded is kept, and the transfer continues to its end.
- R8: With freeze low and status 100, `err_crc` changes status to 010. With freeze low, every error input is ignored when status is an error code or 000.
- R9: During and after reset, freeze, `data_ready` and `cfg_wen` are 0 and status is 000. Status never shows a code above 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins an operation when freeze is low |
| word_total | input | CNT_W | Bitstream length in words, sampled with start |
| data | input | DATA_W | Stream word |
| data_valid | input | 1 | Source holds a word |
| data_ready | output | 1 | Sink takes the word this cycle if valid |
| err_cfg | input | 1 | Injected configuration error |
| err_incompat | input | 1 | Injected incompatible-bitstream error |
| err_crc | input | 1 | Injected CRC error (also late, after success) |
| freeze | output | 1 | High for the whole operation |
| status | output | 3 | 000 none/busy, 001 config error, 010 CRC error, 011 incompatible, 100 success |
| cfg_wdata | output | DATA_W | Accepted word toward the configuration writer |
| cfg_wen | output | 1 | Write strobe for cfg_wdata |

## Verification
Two situations are hard to reach from the ports. The first is a CRC error that lands after a clean completion. The stimulus finishes a whole paced transfer and its drain, and it waits for freeze to fall. It then pulses the CRC input once. It repeats this after a failed run to show that an existing error code is kept. The second is the moment an error arrives. This is tied to the count of words the bench has seen accepted, not to a cycle number. That puts errors on the first word, on the last word, together with one another, and beside a second start that must not restart the count.

// File: rtl/bsink_pkg.sv
package bsink_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } bs_state_e;

  localparam logic [2:0] STS_NONE     = 3'b000;
  localparam logic [2:0] STS_CFG_ERR  = 3'b001;
  localparam logic [2:0] STS_CRC_ERR  = 3'b010;
  localparam logic [2:0] STS_INCOMPAT = 3'b011;
  localparam logic [2:0] STS_OK       = 3'b100;
endpackage

// File: rtl/bsink_pacer.sv
// Acceptance pacer: one tick in every RATIO cycles while active,
// phase restarted so the first active cycle ticks.
module bsink_pacer #(
  parameter int RATIO = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic tick
);
  localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (active) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign tick = active && (phase_q == '0);
endmodule

// File: rtl/bsink_seq.sv
// Operation sequencer: word countdown, then a fixed drain period.
module bsink_seq
  import bsink_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DRAIN_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] word_total,
  input  logic             accept,
  output bs_state_e        state,
  output logic             start_go,
  output logic             drain_last
);
  localparam int DR_W = $clog2(DRAIN_CYC + 1);
  localparam logic [DR_W-1:0] DR_LOAD = DR_W'(DRAIN_CYC);

  bs_state_e        state_q;
  logic [CNT_W-1:0] words_left_q;
  logic [DR_W-1:0]  drain_q;
  logic             last_word;

  assign start_go   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign last_word  = (words_left_q <= CNT_W'(1));
  assign drain_last = (state_q == ST_DRAIN) && (drain_q <= DR_W'(1));
  assign state      = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      words_left_q <= '0;
      drain_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_go) begin
            state_q      <= ST_XFER;
            words_left_q <= word_total;
          end
        end
        ST_XFER: begin
          if (accept) begin
            if (last_word) begin
              state_q <= ST_DRAIN;
              drain_q <= DR_LOAD;
            end else begin
              words_left_q <= words_left_q - 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (drain_last) begin
            state_q <= ST_DONE;
          end else begin
            drain_q <= drain_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsink_status.sv
// Result register: cleared on start, first error kept, success at the end
// of the drain, and a CRC error may replace success after the end.
module bsink_status
  import bsink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       busy,
  input  logic       finish,
  input  logic       after_end,
  input  logic       err_cfg,
  input  logic       err_incompat,
  input  logic       err_crc,
  output logic [2:0] status
);
  logic [2:0] sts_q;
  logic [2:0] err_code;
  logic       any_err;

  always_comb begin
    any_err = err_cfg || err_incompat || err_crc;
    if (err_incompat)  err_code = STS_INCOMPAT;
    else if (err_cfg)  err_code = STS_CFG_ERR;
    else               err_code = STS_CRC_ERR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= STS_NONE;
    end else if (clear) begin
      sts_q <= STS_NONE;
    end else if (busy && (sts_q == STS_NONE) && any_err) begin
      sts_q <= err_code;
    end else if (finish && (sts_q == STS_NONE)) begin
      sts_q <= STS_OK;
    end else if (after_end && (sts_q == STS_OK) && err_crc) begin
      sts_q <= STS_CRC_ERR;
    end
  end

  assign status = sts_q;
endmodule

// File: rtl/bitstream_sink.sv
module bitstream_sink
  import bsink_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int RATIO     = 3,
  parameter int DRAIN_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_total,
  input  logic [DATA_W-1:0] data,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic              err_cfg,
  input  logic              err_incompat,
  input  logic              err_crc,
  output logic              freeze,
  output logic [2:0]        status,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic              cfg_wen
);
  bs_state_e state;
  logic      start_go;
  logic      drain_last;
  logic      tick;
  logic      in_xfer;
  logic      accept;

  assign in_xfer    = (state == ST_XFER);
  assign data_ready = tick;
  assign accept     = tick && data_valid;
  assign freeze     = (state == ST_XFER) || (state == ST_DRAIN);
  assign cfg_wen    = accept;
  assign cfg_wdata  = data;

  bsink_pacer #(
    .RATIO (RATIO)
  ) pacer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_go),
    .active  (in_xfer),
    .tick    (tick)
  );

  bsink_seq #(
    .CNT_W     (CNT_W),
    .DRAIN_CYC (DRAIN_CYC)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_total (word_total),
    .accept     (accept),
    .state      (state),
    .start_go   (start_go),
    .drain_last (drain_last)
  );

  bsink_status status_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (start_go),
    .busy         (freeze),
    .finish       (drain_last),
    .after_end    (state == ST_DONE),
    .err_cfg      (err_cfg),
    .err_incompat (err_incompat),
    .err_crc      (err_crc),
    .status       (status)
  );
endmodule

// File: rtl/bsink_checker.sv
module bsink_checker #(
  parameter int RATIO = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       data_ready,
  input logic       freeze,
  input logic [2:0] status,
  input logic       cfg_wen
);
  // R1: an accepted start raises freeze next cycle
  a_r1_freeze_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !freeze) |=> freeze);

  // R2: status cleared by the start edge
  a_r2_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !freeze) |=> (status == 3'b000));

  // R3: words only pass on while the operation runs
  a_r3_wen_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wen |-> freeze);

  // R4: ready only during an operation
  a_r4_ready_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> freeze);

  // R4: ready never on two cycles in a row when pacing is active
  generate
    if (RATIO > 1) begin : g_spacing
      a_r4_ready_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |=> !data_ready);
    end
  endgenerate

  // R6: success code never shown while frozen
  a_r6_no_ok_busy: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (status != 3'b100));

  // R6: release of freeze always comes with a result
  a_r6_result_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze) |-> (status != 3'b000));

  // R9: only defined codes
  a_r9_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'b100);
endmodule

bind bitstream_sink bsink_checker #(
  .RATIO (RATIO)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .data_ready (data_ready),
  .freeze     (freeze),
  .status     (status),
  .cfg_wen    (cfg_wen)
);

// File: tb/bitstream_sink_tb_top.sv
module bitstream_sink_tb_top;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int RATIO     = 3;
  localparam int DRAIN_CYC = 8;

  typedef struct packed {
    logic [7:0] words;
    logic       late_valid;
    logic [2:0] err_kind;   // 0 none, 1 cfg, 2 crc, 3 incompat, 4 all three
    logic [7:0] err_at;     // accepted-word count at which to inject
    logic       late_crc;
    logic [7:0] restart_at; // cycle of a second start, 0 = none
    logic [2:0] exp_sts;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'd4, 1'b0, 3'd0, 8'd0, 1'b0, 8'd0, 3'b100},
    '{8'd5, 1'b1, 3'd0, 8'd0, 1'b1, 8'd0, 3'b010},
    '{8'd6, 1'b0, 3'd1, 8'd2, 1'b1, 8'd0, 3'b001},
    '{8'd3, 1'b0, 3'd3, 8'd1, 1'b0, 8'd0, 3'b011},
    '{8'd1, 1'b0, 3'd2, 8'd0, 1'b0, 8'd0, 3'b010},
    '{8'd0, 1'b0, 3'd0, 8'd0, 1'b0, 8'd0, 3'b100},
    '{8'd7, 1'b1, 3'd4, 8'd6, 1'b0, 8'd0, 3'b011},
    '{8'd3, 1'b0, 3'd0, 8'd0, 1'b0, 8'd4, 3'b100}
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [CNT_W-1:0]  word_total;
  logic [DATA_W-1:0] data;
  logic              data_valid;
  logic              data_ready;
  logic              err_cfg;
  logic              err_incompat;
  logic              err_crc;
  logic              freeze;
  logic [2:0]        status;
  logic [DATA_W-1:0] cfg_wdata;
  logic              cfg_wen;

  int n_checks;
  int n_fail;

  bitstream_sink #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .RATIO     (RATIO),
    .DRAIN_CYC (DRAIN_CYC)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .word_total   (word_total),
    .data         (data),
    .data_valid   (data_valid),
    .data_ready   (data_ready),
    .err_cfg      (err_cfg),
    .err_incompat (err_incompat),
    .err_crc      (err_crc),
    .freeze       (freeze),
    .status       (status),
    .cfg_wdata    (cfg_wdata),
    .cfg_wen      (cfg_wen)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(input logic [2:0] kind);
    case (kind)
      3'd1:    return 3'b001;
      3'd2:    return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  task automatic idle_inputs();
    start = 1'b0; data_valid = 1'b0; err_cfg = 1'b0;
    err_incompat = 1'b0; err_crc = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int  n_words;
    int  accepts;
    int  last_ready;
    int  drain_seen;
    bit  gap_bad;
    bit  post_bad;
    bit  data_bad;
    bit  injected;
    bit  inj_check;
    bit  first_ok;
    bit  done;
    n_words = (v.words == 0) ? 1 : int'(v.words);
    accepts = 0; last_ready = -1; drain_seen = 0;
    gap_bad = 0; post_bad = 0; data_bad = 0;
    injected = 0; inj_check = 0; first_ok = 0; done = 0;

    @(negedge clk);
    idle_inputs();
    start = 1'b1;
    word_total = CNT_W'(v.words);
    for (int c = 1; c < 600 && !done; c++) begin
      @(negedge clk);
      start = (v.restart_at != 0) && (c == int'(v.restart_at));
      word_total = CNT_W'(v.words) + CNT_W'(5);
      data_valid = v.late_valid ? (c >= 5) : 1'b1;
      data = 32'hA500_0000 + DATA_W'(accepts);
      err_cfg = 1'b0; err_incompat = 1'b0; err_crc = 1'b0;
      if (v.err_kind != 0 && !injected && accepts == int'(v.err_at)) begin
        injected = 1;
        err_cfg      = (v.err_kind == 3'd1) || (v.err_kind == 3'd4);
        err_crc      = (v.err_kind == 3'd2) || (v.err_kind == 3'd4);
        err_incompat = (v.err_kind == 3'd3) || (v.err_kind == 3'd4);
      end
      #3;
      if (c == 1) begin
        first_ok = freeze && (status == 3'b000) && data_ready;
      end
      if (inj_check) begin
        inj_check = 0;
        check(freeze && status == code_of(v.err_kind), "R7 error code while busy",
              int'(status), int'(code_of(v.err_kind)));
      end
      if (injected && err_cfg | err_crc | err_incompat) inj_check = 1;
      if (!freeze) begin
        done = 1;
      end else if (accepts >= n_words) begin
        drain_seen++;
        if (data_ready || cfg_wen) post_bad = 1;
      end else begin
        if (data_ready) begin
          if (last_ready >= 0 && (c - last_ready) != RATIO) gap_bad = 1;
          last_ready = c;
        end
        if (cfg_wen) begin
          if (!(data_ready && data_valid) || cfg_wdata != data) data_bad = 1;
          accepts++;
        end else if (data_ready && data_valid) begin
          data_bad = 1;
        end
      end
    end
    idle_inputs();
    check(done, "R6 freeze released", int'(done), 1);
    check(first_ok, "R1 R2 R4 first cycle freeze/status/ready", int'(first_ok), 1);
    check(accepts == n_words, "R3 R1 words accepted", accepts, n_words);
    check(!data_bad, "R3 forward on handshake only", int'(data_bad), 0);
    check(!gap_bad, "R4 ready one in RATIO", int'(gap_bad), 0);
    check(!post_bad, "R5 no ready after last word", int'(post_bad), 0);
    check(drain_seen == DRAIN_CYC, "R6 drain length", drain_seen, DRAIN_CYC);
    if (v.late_crc) begin
      @(negedge clk);
      err_crc = 1'b1;
      @(negedge clk);
      err_crc = 1'b0;
      #3;
      check(status == v.exp_sts, "R8 late CRC", int'(status), int'(v.exp_sts));
    end else begin
      check(status == v.exp_sts, "R6 R7 final status", int'(status), int'(v.exp_sts));
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    #150000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    word_total = '0;
    data = '0;
    repeat (3) @(negedge clk);
    #3;
    check(!freeze && !data_ready && !cfg_wen && status == 3'b000,
          "R9 reset state", int'(status), 0);
    @(negedge clk);
    rst_n = 1'b1;
    data_valid = 1'b1;
    #3;
    check(!freeze && !data_ready && !cfg_wen, "R9 idle after reset", int'(freeze), 0);

    // R8: errors in idle from reset are ignored
    @(negedge clk);
    err_cfg = 1'b1; err_crc = 1'b1; err_incompat = 1'b1;
    @(negedge clk);
    idle_inputs();
    #3;
    check(status == 3'b000 && !freeze, "R8 idle errors ignored", int'(status), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i]);
    end

    // R8: late CRC after an error-terminated run is ignored
    run_vec('{8'd2, 1'b0, 3'd1, 8'd1, 1'b1, 8'd0, 3'b001});
    // R2: a new start clears the previous error code
    @(negedge clk);
    start = 1'b1; word_total = CNT_W'(2);
    @(negedge clk);
    start = 1'b0;
    #3;
    check(status == 3'b000 && freeze, "R2 status cleared on restart", int'(status), 0);
    // R5: dummy fill never reaches the writer before the drain ends
    data_valid = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      #3;
      if (!freeze) break;
    end
    data_valid = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    check(!cfg_wen && !data_ready && status == 3'b100, "R5 R8 no accept after end",
          int'(cfg_wen), 0);
    idle_inputs();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule